// File: doc/BRIEF.md
# Manchester Word Receiver with Clock Recovery

This block turns one serial Manchester-coded line, already taken from whichever bus is active, back into 20-bit-time words. The bit rate is 1 Mbit/s. The receiver runs on a single system clock whose frequency in MHz is set by the parameter `CLK_MHZ` (12, 16, 20 or 24). Each half bit therefore lasts H = `CLK_MHZ`/2 clock cycles. The line is first passed through a two-flop synchronizer. A run-length counter then looks for the three-bit-time sync pattern. After a sync it hands over to a small digital phase tracker. The tracker counts H cycles per half bit, samples each half near its centre, and pulls its phase back onto every transition that lands near the middle of a bit.

For each word the block returns the 16 data bits and a type flag taken from the sync polarity. It also returns two independent error flags, one for Manchester coding and one for parity, all qualified by a one-cycle valid strobe. When the line holds a level or carries a malformed sync, the block stays quiet. Words that follow one another with no gap are each recovered, because the sync search restarts at the boundary of the word just finished.

Top module: `mrx_word_receiver`

## Requirements
- R1: After reset `valid_o`, `word_o`, `is_cmd_o`, `man_err_o` and `par_err_o` are all 0.
- R2: A sync is accepted when the line holds one level for 3H-1 to 3H+1 cycles and then holds the opposite level for at least 3H-1 cycles. `is_cmd_o` is 1 when the first sync level was high (command/status word) and 0 when it was low (data word).
- R3: No word is produced when the first sync level lasts 3H-2 or 3H+2 cycles, or when the second sync level lasts only 3H-2 cycles.
- R4: Each of the 17 bits after the sync takes the value of its first half: high-then-low is 1 and low-then-high is 0. The first data bit received lands in `word_o[15]` and the sixteenth in `word_o[0]`.
- R5: The 17th bit is parity. `par_err_o` is 1 exactly when the number of ones across the 16 data bits and the parity bit is even.
- R6: A bit whose two halves carry the same level sets `man_err_o`. The word is still delivered, with that bit taking the level of its halves. `par_err_o` is judged on the recovered bits.
- R7: `valid_o` is high for exactly one cycle per recovered word. `word_o`, `is_cmd_o`, `man_err_o` and `par_err_o` hold their values until the next strobe.
- R8: Words whose half bits last H-1 or H+1 cycles instead of H are recovered correctly, because the sampling phase re-aligns on every mid-bit transition.
- R9: A word whose sync starts right after the previous word's parity bit, with no idle gap, is recovered, including a data-type sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `CLK_MHZ` MHz |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Serial Manchester data from the selected bus |
| word_o | output | 16 | Recovered data bits, first received in bit 15 |
| is_cmd_o | output | 1 | 1 for command/status sync, 0 for data sync |
| valid_o | output | 1 | One-cycle strobe marking a new word |
| man_err_o | output | 1 | Manchester coding violation in the word |
| par_err_o | output | 1 | Odd parity check failed |

## Verification
The hardest cases to reach from the ports are the narrow acceptance edges of the sync detector and the phase tracker's ability to follow a transmitter that runs fast or slow. The bench builds every word from half-bit segments whose lengths are counted in clock cycles. This lets it place each sync level exactly one cycle inside or outside the ±1 tolerance, and stretch or shrink every half bit by one cycle for a whole word. Coding violations are swept over all 17 bit positions. Back-to-back words are sent with no idle gap to reach the restart path at a word boundary.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  typedef struct packed {
    logic [15:0] data;
    logic        cmd;
    logic        man_err;
    logic        par_err;
  } mrx_word_t;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_WORD = 1'b1
  } mrx_state_t;

endpackage

// File: rtl/mrx_line_front.sv
module mrx_line_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic lvl_o,
  output logic edge_o
);

  logic [STAGES-1:0] chain;
  logic              lvl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      lvl_d <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      lvl_d <= chain[STAGES-1];
    end
  end

  assign lvl_o  = chain[STAGES-1];
  assign edge_o = chain[STAGES-1] ^ lvl_d;

endmodule

// File: rtl/mrx_sync_hunt.sv
module mrx_sync_hunt #(
  parameter int HALF = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  input  logic edge_i,
  input  logic arm_i,
  input  logic restart_i,
  output logic hit_o,
  output logic hit_cmd_o
);

  localparam int SYNC_LEN = 3 * HALF;
  localparam int RMAX     = SYNC_LEN + 3;
  localparam int RW       = $clog2(RMAX + 1);

  logic [RW-1:0] run;
  logic          first_ok;
  logic          first_hi;

  // run holds the number of cycles the current level has been seen before this one
  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= RW'(1);
      first_ok <= 1'b0;
      first_hi <= 1'b0;
    end else if (restart_i) begin
      run      <= RW'(1);
      first_ok <= 1'b0;
    end else if (edge_i) begin
      run      <= RW'(1);
      first_ok <= (run >= RW'(SYNC_LEN - 1)) && (run <= RW'(SYNC_LEN + 1));
      first_hi <= ~lvl_i;
    end else begin
      if (run != RW'(RMAX)) run <= run + RW'(1);
      if (hit_o) first_ok <= 1'b0;
    end
  end

  // fires in the (3H-1)th cycle of the second level, so a second level of 3H-2 never fires
  assign hit_o     = arm_i & first_ok & ~edge_i & ~restart_i & (run == RW'(SYNC_LEN - 2));
  assign hit_cmd_o = first_hi;

  assert_run_live_R2: assert property (@(posedge clk) disable iff (rst)
    run != '0);

  assert_hit_clears_R3: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o);

endmodule

// File: rtl/mrx_deser.sv
module mrx_deser
  import mrx_pkg::*;
#(
  parameter int HALF = 6,
  parameter int BITS = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_i,
  input  logic      edge_i,
  input  logic      start_i,
  input  logic      start_cmd_i,
  output logic      busy_o,
  output logic      restart_o,
  output logic      valid_o,
  output mrx_word_t word_o
);

  localparam int PW     = $clog2(HALF);
  localparam int BW     = $clog2(BITS + 1);
  localparam int SAMPLE = HALF / 2;
  localparam int WIN    = 2;

  mrx_state_t      state;
  logic [PW-1:0]   ph;
  logic            half;
  logic [BW-1:0]   bitn;
  logic            first_q;
  logic            cmd_q;
  logic            man_q;
  logic [BITS-1:0] shift;
  logic            in_window;
  logic            last_bit;

  assign in_window = (!half && ph >= PW'(HALF - 2)) || (half && ph <= PW'(WIN));
  assign last_bit  = (bitn == BW'(BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      ph        <= '0;
      half      <= 1'b0;
      bitn      <= '0;
      first_q   <= 1'b0;
      cmd_q     <= 1'b0;
      man_q     <= 1'b0;
      shift     <= '0;
      valid_o   <= 1'b0;
      restart_o <= 1'b0;
      word_o    <= '0;
    end else begin
      valid_o   <= 1'b0;
      restart_o <= 1'b0;
      case (state)
        ST_HUNT: begin
          if (start_i) begin
            state <= ST_WORD;
            ph    <= '0;
            half  <= 1'b0;
            bitn  <= '0;
            cmd_q <= start_cmd_i;
            man_q <= 1'b0;
          end
        end
        ST_WORD: begin
          // phase tracking: a transition near mid-bit marks cycle 0 of the second half
          if (edge_i && in_window) begin
            half <= 1'b1;
            ph   <= PW'(1);
          end else if (ph == PW'(HALF - 1)) begin
            ph   <= '0;
            half <= ~half;
            if (half) begin
              if (last_bit) begin
                state     <= ST_HUNT;
                restart_o <= 1'b1;
              end else begin
                bitn <= bitn + BW'(1);
              end
            end
          end else begin
            ph <= ph + PW'(1);
          end

          if (!half && ph == PW'(SAMPLE)) first_q <= lvl_i;

          if (half && ph == PW'(SAMPLE)) begin
            if (last_bit) begin
              valid_o        <= 1'b1;
              word_o.data    <= shift;
              word_o.cmd     <= cmd_q;
              word_o.man_err <= man_q | (first_q == lvl_i);
              word_o.par_err <= ~(^{shift, first_q});
            end else begin
              shift <= {shift[BITS-2:0], first_q};
              man_q <= man_q | (first_q == lvl_i);
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

  assign busy_o = (state == ST_WORD);

  assert_phase_bound_R8: assert property (@(posedge clk) disable iff (rst)
    ph < PW'(HALF));

  assert_bit_index_R4: assert property (@(posedge clk) disable iff (rst)
    bitn <= BW'(BITS));

  assert_restart_leaves_word_R9: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> !busy_o);

endmodule

// File: rtl/mrx_word_receiver.sv
module mrx_word_receiver
  import mrx_pkg::*;
#(
  parameter int CLK_MHZ = 12
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        line_i,
  output logic [15:0] word_o,
  output logic        is_cmd_o,
  output logic        valid_o,
  output logic        man_err_o,
  output logic        par_err_o
);

  localparam int HALF = CLK_MHZ / 2;

  initial begin
    assert_clock_choice_R2: assert (CLK_MHZ == 12 || CLK_MHZ == 16 ||
                                    CLK_MHZ == 20 || CLK_MHZ == 24)
      else $error("unsupported CLK_MHZ %0d", CLK_MHZ);
  end

  logic      lvl;
  logic      edge_seen;
  logic      hit;
  logic      hit_cmd;
  logic      busy;
  logic      restart;
  logic      strobe;
  mrx_word_t word;

  mrx_line_front #(.STAGES(2)) u_front (
    .clk    (clk),
    .rst    (rst),
    .line_i (line_i),
    .lvl_o  (lvl),
    .edge_o (edge_seen)
  );

  mrx_sync_hunt #(.HALF(HALF)) u_hunt (
    .clk       (clk),
    .rst       (rst),
    .lvl_i     (lvl),
    .edge_i    (edge_seen),
    .arm_i     (~busy),
    .restart_i (restart),
    .hit_o     (hit),
    .hit_cmd_o (hit_cmd)
  );

  mrx_deser #(.HALF(HALF), .BITS(16)) u_deser (
    .clk         (clk),
    .rst         (rst),
    .lvl_i       (lvl),
    .edge_i      (edge_seen),
    .start_i     (hit),
    .start_cmd_i (hit_cmd),
    .busy_o      (busy),
    .restart_o   (restart),
    .valid_o     (strobe),
    .word_o      (word)
  );

  assign word_o    = word.data;
  assign is_cmd_o  = word.cmd;
  assign man_err_o = word.man_err;
  assign par_err_o = word.par_err;
  assign valid_o   = strobe;

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_sync_starts_word_R2: assert property (@(posedge clk) disable iff (rst)
    hit |=> busy);

  assert_strobe_inside_word_R7: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> busy);

endmodule

// File: tb/test_mrx_word_receiver.sv
module test_mrx_word_receiver;

  localparam int CLK_PERIOD = 10;
  localparam int MHZ        = 12;
  localparam int H          = MHZ / 2;
  localparam int S          = 3 * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line = 1'b0;
  logic [15:0] word_o;
  logic        is_cmd_o, valid_o, man_err_o, par_err_o;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mrx_word_receiver #(.CLK_MHZ(MHZ)) i_mrx_word_receiver (
    .clk       (clk),
    .rst       (rst),
    .line_i    (line),
    .word_o    (word_o),
    .is_cmd_o  (is_cmd_o),
    .valid_o   (valid_o),
    .man_err_o (man_err_o),
    .par_err_o (par_err_o)
  );

  int total = 0;
  int bad   = 0;
  int nval  = 0;
  int vrun  = 0;
  int vmax  = 0;
  logic [15:0] cap_w [0:15];
  logic        cap_c [0:15];
  logic        cap_m [0:15];
  logic        cap_p [0:15];

  always @(negedge clk) begin
    if (!rst) begin
      if (valid_o) begin
        cap_w[nval % 16] = word_o;
        cap_c[nval % 16] = is_cmd_o;
        cap_m[nval % 16] = man_err_o;
        cap_p[nval % 16] = par_err_o;
        nval = nval + 1;
        vrun = vrun + 1;
        if (vrun > vmax) vmax = vrun;
      end else begin
        vrun = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic odd_par(input logic [15:0] d);
    return ~(^d);
  endfunction

  task automatic send_word(input logic cmd, input logic [15:0] d, input int s1, input int s2,
                           input int merr, input logic pflip, input int h0, input int h1);
    logic b;
    drive(cmd, s1);
    drive(~cmd, s2);
    for (int i = 0; i < 17; i++) begin
      b = (i < 16) ? d[15-i] : (odd_par(d) ^ pflip);
      drive(b, h0);
      drive((i == merr) ? b : ~b, h1);
    end
  endtask

  task automatic expect_word(input string tag, input int n0, input logic [15:0] d,
                             input logic c, input logic m, input logic p);
    chk({tag, " count"}, nval, n0 + 1);
    chk({tag, " word"}, word_o, d);
    chk({tag, " R2 type"}, is_cmd_o, c);
    chk({tag, " man"}, man_err_o, m);
    chk({tag, " par"}, par_err_o, p);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic        c;
    int          n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", valid_o, 0);
    chk("R1 word", word_o, 0);
    chk("R1 type", is_cmd_o, 0);
    chk("R1 man", man_err_o, 0);
    chk("R1 par", par_err_o, 0);
    drive(0, 30);

    // R4 / R2: data sweep with both sync types
    for (int i = 0; i < 32; i++) begin
      case (i)
        0: d = 16'h0000;
        1: d = 16'hFFFF;
        2: d = 16'h8000;
        3: d = 16'h0001;
        default: d = 16'(i * 16'h1357) ^ 16'(i << 9);
      endcase
      c = (i % 4) != 3;
      if (!c) drive(1, 40);
      n0 = nval;
      send_word(c, d, S, S, -1, 1'b0, H, H);
      drive(0, 30);
      expect_word("R4", n0, d, c, 1'b0, 1'b0);
    end

    // R7: fields hold between strobes
    drive(0, 100);
    chk("R7 hold word", word_o, d);
    chk("R7 hold valid", valid_o, 0);

    // R5: parity errors
    for (int i = 0; i < 4; i++) begin
      d = 16'hA5A5 ^ 16'(i * 16'h0F11);
      n0 = nval;
      send_word(1'b1, d, S, S, -1, 1'b1, H, H);
      drive(0, 30);
      expect_word("R5", n0, d, 1'b1, 1'b0, 1'b1);
    end

    // R6: coding violation at every bit position
    for (int pos = 0; pos < 17; pos++) begin
      d = 16'hC3A5;
      n0 = nval;
      send_word(1'b1, d, S, S, pos, 1'b0, H, H);
      drive(0, 30);
      expect_word("R6", n0, d, 1'b1, 1'b1, 1'b0);
    end

    // R2: sync lengths inside tolerance
    for (int a = -1; a <= 1; a++) begin
      for (int b = -1; b <= 1; b++) begin
        d = 16'hB00B ^ 16'((a + 2) * 16'h0110 + (b + 2));
        n0 = nval;
        send_word(1'b1, d, S + a, S + b, -1, 1'b0, H, H);
        drive(0, 30);
        expect_word("R2", n0, d, 1'b1, 1'b0, 1'b0);
      end
    end

    // R3: sync lengths outside tolerance (bit 15 set so the second level ends on time)
    n0 = nval;
    send_word(1'b1, 16'hB00B, S - 2, S, -1, 1'b0, H, H);
    drive(0, 40);
    chk("R3 first short", nval, n0);
    n0 = nval;
    send_word(1'b1, 16'hB00B, S + 2, S, -1, 1'b0, H, H);
    drive(0, 40);
    chk("R3 first long", nval, n0);
    n0 = nval;
    send_word(1'b1, 16'hB00B, S, S - 2, -1, 1'b0, H, H);
    drive(0, 40);
    chk("R3 second short", nval, n0);

    // R8: transmitter running fast or slow
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 3; j++) begin
        d = (j == 0) ? 16'hAAAA : (j == 1) ? 16'h0F0F : 16'h1234 ^ 16'(k * 16'h1111);
        n0 = nval;
        send_word(1'b1, d, S, S, -1, 1'b0, (k[0] ? H + 1 : H - 1), (k[1] ? H + 1 : H - 1));
        drive(0, 30);
        expect_word("R8", n0, d, 1'b1, 1'b0, 1'b0);
      end
    end

    // R9: back-to-back words with no gap
    for (int t = 0; t < 2; t++) begin
      n0 = nval;
      send_word(1'b1, 16'h2C41 ^ 16'(t), S, S, -1, 1'b0, H, H);
      send_word(1'b0, 16'hFFFE ^ 16'(t), S, S, -1, 1'b0, H, H);
      send_word(1'b0, 16'h0003 ^ 16'(t << 4), S, S, -1, 1'b0, H, H);
      send_word(1'b0, 16'h7E81, S, S, -1, 1'b0, H, H);
      drive(0, 40);
      chk("R9 count", nval, n0 + 4);
      chk("R9 w0", {cap_c[(n0) % 16], cap_w[(n0) % 16]}, {1'b1, 16'h2C41 ^ 16'(t)});
      chk("R9 w1", {cap_c[(n0 + 1) % 16], cap_w[(n0 + 1) % 16]}, {1'b0, 16'hFFFE ^ 16'(t)});
      chk("R9 w2", {cap_c[(n0 + 2) % 16], cap_w[(n0 + 2) % 16]}, {1'b0, 16'h0003 ^ 16'(t << 4)});
      chk("R9 w3", {cap_c[(n0 + 3) % 16], cap_w[(n0 + 3) % 16]}, {1'b0, 16'h7E81});
      chk("R9 flags", {cap_m[(n0 + 3) % 16], cap_p[(n0 + 3) % 16]}, 0);
    end

    chk("R7 strobe width", vmax, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule